// File: doc/BRIEF.md
# Three-Wire Radio Register Serial Master

This block moves register values between a host and the control port of a radio front end. The control port has four lines: an active-low frame enable, a serial clock, a bidirectional data line and a direction line that marks the returned part of a read. The host asks for a transfer with a valid/ready handshake. A write carries a 4-bit register address and 12 bits of data. A read carries a 5-bit register address and gives back 12 bits of data. When a transfer finishes, the block raises a one-cycle done strobe.

A write goes out as a single 16-bit word, most significant bit first. The upper twelve bits are the data and the lowest four bits are the address. A read drives the five address bits, most significant bit first, and then raises the direction line. The block then lets go of the data line so the radio can drive it, and it clocks in twelve bits. The serial clock is built from the system clock. Each low phase and each high phase lasts `DIV` system cycles. The data pad is split into an output, an output enable and an input, so the tri-state buffer sits outside the block.

Top module: `rf3w_master`

## Requirements
- R1: After reset, req_ready=1, rf_en=1, rf_clk=0, rf_dir=0, rf_doe=1 and done=0.
- R2: A write sends exactly 16 bits on rf_dout, most significant first, as {req_wdata[11:0], req_addr[3:0]}. Each bit is taken on a rising edge of rf_clk, with rf_doe=1 and rf_dir=0, and no bits are taken in.
- R3: A read first sends exactly 5 bits, req_addr[4:0], most significant first, with rf_doe=1 and rf_dir=0.
- R4: After the fifth address bit, rf_dir goes to 1 and rf_doe goes to 0, and both keep those values until the frame closes. The block then gives exactly 12 rf_clk high phases. At each one it samples rf_din, most significant bit first, and the 12-bit result appears on rd_data when done rises.
- R5: rf_en is high for at least DIV cycles before it falls, stays low across every rf_clk pulse of the frame, and is high again when done rises. rf_clk is low whenever rf_en is high.
- R6: rf_dout does not change while rf_clk is high.
- R7: Every high phase of rf_clk lasts exactly DIV system cycles.
- R8: done rises exactly 36*DIV cycles after the clock edge that accepts a write, and exactly 39*DIV cycles after the edge that accepts a read.
- R9: A request is accepted only while req_ready=1. req_ready falls on the cycle after acceptance, and req_valid held high while busy starts no second frame.
- R10: done lasts one cycle. rd_data changes only when done rises at the end of a read, so a write leaves it unchanged.
- R11: A write ignores req_addr[4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 5 | Register address (writes use bits 3:0) |
| req_wdata | input | 12 | Write data |
| done | output | 1 | One-cycle end-of-transfer strobe |
| rd_data | output | 12 | Last read result |
| rf_en | output | 1 | Frame enable, low during a frame |
| rf_clk | output | 1 | Serial clock |
| rf_dir | output | 1 | High during the returned-data part of a read |
| rf_dout | output | 1 | Data pad output value |
| rf_doe | output | 1 | Data pad output enable |
| rf_din | input | 1 | Data pad input value |

## Verification
The bench sweeps every write address, with the unused fifth address bit both clear and set. Each address is tried with all-ones data, all-zeros data and two data patterns that depend on the address. A swap of address and data fields, a lost bit, a reversed bit order, or a decode of the ignored bit would each give a different captured word. Reads cover all 32 addresses with three return patterns that mix alternating bits and values that depend on the address, which exposes an off-by-one in the turnaround or a wrong sample phase. One write of each address keeps the request valid with changed contents while the block is busy, so a second accepted frame would show up in the bit counts. A final read, write and check sequence confirms that the read result is kept.

// File: rtl/rf3w_master.sv
module rf3w_master #(
  parameter int DIV = 4,
  parameter int WA  = 4,
  parameter int RA  = 5,
  parameter int DW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_read,
  input  logic [RA-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          rf_en,
  output logic          rf_clk,
  output logic          rf_dir,
  output logic          rf_dout,
  output logic          rf_doe,
  input  logic          rf_din
);

  localparam int FW  = DW + WA;
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int NBW = $clog2(FW + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_LEAD, S_LOW, S_HIGH, S_TURN, S_TAIL, S_END
  } st_t;

  st_t            state;
  logic [CW-1:0]  cnt;
  logic [NBW-1:0] nbit;
  logic [FW-1:0]  tx;
  logic [DW-1:0]  rx;
  logic           rd_q;
  logic           en_q, sclk_q, dir_q, dout_q, doe_q, done_q;
  logic [DW-1:0]  rdata_q;
  logic           last;

  assign last      = (cnt == CW'(DIV - 1));
  assign req_ready = (state == S_IDLE);
  assign done      = done_q;
  assign rd_data   = rdata_q;
  assign rf_en     = en_q;
  assign rf_clk    = sclk_q;
  assign rf_dir    = dir_q;
  assign rf_dout   = dout_q;
  assign rf_doe    = doe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      nbit    <= '0;
      tx      <= '0;
      rx      <= '0;
      rd_q    <= 1'b0;
      en_q    <= 1'b1;
      sclk_q  <= 1'b0;
      dir_q   <= 1'b0;
      dout_q  <= 1'b0;
      doe_q   <= 1'b1;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (state == S_IDLE) begin
        cnt <= '0;
        if (req_valid) begin
          state <= S_START;
          rd_q  <= req_read;
          if (req_read) begin
            tx   <= {req_addr, {(FW - RA){1'b0}}};
            nbit <= NBW'(RA);
          end else begin
            tx   <= {req_wdata, req_addr[WA-1:0]};
            nbit <= NBW'(FW);
          end
        end
      end else if (!last) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (state)
          S_START: begin
            state <= S_LEAD;
            en_q  <= 1'b0;
          end
          S_LEAD: begin
            state  <= S_LOW;
            dout_q <= tx[FW-1];
            tx     <= {tx[FW-2:0], 1'b0};
          end
          S_LOW: begin
            state  <= S_HIGH;
            sclk_q <= 1'b1;
          end
          S_HIGH: begin
            sclk_q <= 1'b0;
            nbit   <= nbit - 1'b1;
            if (dir_q) rx <= {rx[DW-2:0], rf_din};
            if (nbit != NBW'(1)) begin
              state <= S_LOW;
              if (!dir_q) begin
                dout_q <= tx[FW-1];
                tx     <= {tx[FW-2:0], 1'b0};
              end
            end else if (rd_q && !dir_q) begin
              state <= S_TURN;
              dir_q <= 1'b1;
              doe_q <= 1'b0;
              nbit  <= NBW'(DW);
            end else begin
              state <= S_TAIL;
            end
          end
          S_TURN: state <= S_LOW;
          S_TAIL: begin
            state  <= S_END;
            en_q   <= 1'b1;
            doe_q  <= 1'b1;
            dout_q <= 1'b0;
          end
          S_END: begin
            state  <= S_IDLE;
            dir_q  <= 1'b0;
            done_q <= 1'b1;
            if (rd_q) rdata_q <= rx;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rf3w_master_chk.sv
module rf3w_master_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [DW-1:0] rd_data,
  input logic          rf_en,
  input logic          rf_clk,
  input logic          rf_dir,
  input logic          rf_dout,
  input logic          rf_doe
);

  // R5
  en_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |-> !rf_clk);

  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_clk |-> $stable(rf_dout));

  // R4
  turn_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_doe |-> rf_dir);

  // R4
  dir_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_dir) |-> !rf_en && !rf_doe);

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && rf_en);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data));

endmodule

bind rf3w_master rf3w_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .rd_data(rd_data), .rf_en(rf_en), .rf_clk(rf_clk),
  .rf_dir(rf_dir), .rf_dout(rf_dout), .rf_doe(rf_doe)
);

// File: tb/rf3w_master_bench.sv
module rf3w_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0;
  logic [4:0] req_addr = '0;
  logic [11:0] req_wdata = '0;
  logic req_ready, done;
  logic [11:0] rd_data;
  logic rf_en, rf_clk, rf_dir, rf_dout, rf_doe;
  logic rf_din = 1'b0;

  int n_chk = 0, n_fail = 0;
  int n_out = 0, n_in = 0, fr_err = 0, hi_len = 0, en_hi = 100, rd_idx = 12;
  logic [15:0] sh_out = '0;
  logic [11:0] rd_val = '0;
  logic clk_prev = 1'b0, dir_prev = 1'b0, en_prev = 1'b1, dout_at_rise = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf3w_master #(.DIV(DIV)) u_rf3w_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .rf_en(rf_en), .rf_clk(rf_clk),
    .rf_dir(rf_dir), .rf_dout(rf_dout), .rf_doe(rf_doe), .rf_din(rf_din)
  );

  // radio model and frame observer
  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_clk && !clk_prev) begin
        if (rf_en) fr_err++;
        if (rf_doe) begin
          if (rf_dir) fr_err++;
          sh_out = {sh_out[14:0], rf_dout};
          n_out++;
        end else begin
          if (!rf_dir) fr_err++;
          n_in++;
        end
        hi_len = 1;
        dout_at_rise = rf_dout;
      end else if (rf_clk) begin
        hi_len++;
        if (rf_dout !== dout_at_rise) fr_err++;
      end
      if (!rf_clk && clk_prev && hi_len != DIV) fr_err++;
      if (rf_dir && !dir_prev) rd_idx = 0;
      else if (!rf_clk && clk_prev && !rf_doe) rd_idx++;
      if (!rf_en && en_prev) begin
        if (en_hi < DIV) fr_err++;
        en_hi = 0;
      end
      if (rf_en) en_hi++;
      rf_din = (rd_idx < 12) ? rd_val[11 - rd_idx] : 1'b0;
      clk_prev = rf_clk;
      dir_prev = rf_dir;
      en_prev  = rf_en;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit rd, input logic [4:0] a, input logic [11:0] d,
                      input int hold, output int lat);
    @(negedge clk);
    n_out = 0; n_in = 0; fr_err = 0; sh_out = '0;
    req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk("R9 ready drops after accept", int'(req_ready), 0);
    if (hold == 0) req_valid = 1'b0;
    else begin req_read = !rd; req_addr = ~a; req_wdata = ~d; end
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
      if (lat == hold + 1) req_valid = 1'b0;
    end
    lat = lat - 1;
    chk("R5 enable high at done", int'(rf_en), 1);
    @(negedge clk);
    chk("R10 done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", int'({req_ready, rf_en, rf_clk, rf_dir, rf_doe, done}), 6'b110010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", int'({req_ready, rf_en, rf_clk, rf_dir, rf_doe, done}), 6'b110010);

    for (int a = 0; a < 16; a++) begin
      for (int k = 0; k < 4; k++) begin
        logic [11:0] d;
        logic [4:0] ad;
        case (k)
          0: d = 12'hFFF;
          1: d = 12'h000;
          2: d = 12'(a * 273) ^ 12'hA5A;
          default: d = 12'(a * 257 + 3);
        endcase
        ad = {k[0], 4'(a)};
        xfer(1'b0, ad, d, (k == 3) ? 20 : 0, lat);
        chk("R2 R11 write word", int'(sh_out), int'({d, 4'(a)}));
        chk("R2 R9 write bits out", n_out, 16);
        chk("R2 write bits in", n_in, 0);
        chk("R5 R6 R7 write framing", fr_err, 0);
        chk("R8 write latency", lat, 36 * DIV);
      end
    end

    for (int a = 0; a < 32; a++) begin
      for (int k = 0; k < 3; k++) begin
        case (k)
          0: rd_val = 12'(a * 97 + 5);
          1: rd_val = 12'hAAA ^ 12'(a);
          default: rd_val = 12'h555 ^ 12'(a << 7);
        endcase
        xfer(1'b1, 5'(a), 12'h000, 0, lat);
        chk("R3 read address", int'(sh_out[4:0]), a);
        chk("R3 read bits out", n_out, 5);
        chk("R4 read bits in", n_in, 12);
        chk("R4 read data", int'(rd_data), int'(rd_val));
        chk("R5 R6 R7 read framing", fr_err, 0);
        chk("R8 read latency", lat, 39 * DIV);
      end
    end

    rd_val = 12'h3C7;
    xfer(1'b1, 5'd19, 12'h000, 0, lat);
    rd_val = 12'h000;
    xfer(1'b0, 5'd6, 12'hBEE, 0, lat);
    chk("R10 write keeps rd_data", int'(rd_data), 12'h3C7);
    repeat (10) @(negedge clk);
    chk("R10 rd_data held idle", int'(rd_data), 12'h3C7);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule